// File: doc/BRIEF.md
# Network MAC Event Statistics Bank

This block holds the event counters of a network MAC for both directions of traffic. The transmit engine and the receive engine each hand it one completion report per finished frame, or per finished attempt when an attempt ends in an underrun. Each report carries outcome flags and, on the transmit side, the number of collisions seen. A classifier turns each report into per-counter increments. A counter moves only on the cycle that a report is presented.

Software asks for the counters through two command pulses. Both take a single-cycle snapshot of the whole bank and then stream it out one word per cycle, with a word index beside each word. A done pulse follows the last word. The clearing command also zeroes the live bank on the snapshot cycle. Reports that arrive while the stream is running go into the live bank, so none of them is lost. Counters stick at all-ones instead of wrapping.

Top module: `mac_stats_bank`

## Requirements
- R1: With no completion report and no accepted clearing command, every counter keeps its value from one cycle to the next.
- R2: An accepted command streams the twelve counter values as they stood on the command cycle, one per cycle, with `dump_valid` high and `dump_idx` running 0 to 11. The indices are assigned as follows: 0 tx sent, 1 tx max-collision drop, 2 tx late collision, 3 tx underrun, 4 tx carrier lost, 5 tx deferred, 6 tx one collision, 7 tx several collisions, 8 tx collision total, 9 rx good, 10 rx CRC error, 11 rx misaligned.
- R3: The plain dump command (`cmd_dump`) leaves the counters unchanged.
- R4: The clearing command (`cmd_dump_clr`) zeroes every counter on the snapshot cycle. Reports accepted while its stream runs are counted in the cleared bank.
- R5: A transmit report with `tx_sent` set increments counter 0. If it also has `tx_coll_cnt` equal to 1, it increments counter 6. If it has `tx_coll_cnt` of 2 or more, it increments counter 7.
- R6: Every transmit report adds its full `tx_coll_cnt` to counter 8, whether the frame was sent, dropped at the collision limit, or hit by a late collision.
- R7: `tx_max_coll` increments counter 1 and `tx_late_coll` increments counter 2, whether or not the frame was sent.
- R8: Each transmit report with `tx_underrun` set increments counter 3 by one. A frame that is retried after underruns is therefore counted once per failing attempt.
- R9: `tx_carrier_lost` increments counter 4 only when `tx_sent` is also set. `tx_deferred` increments counter 5 on any transmit report.
- R10: Receive error classes are mutually exclusive. A runt report (`rx_runt`) counts as neither CRC nor alignment error. A bad CRC with `rx_misaligned` set increments only counter 11. A bad CRC on an aligned frame increments only counter 10.
- R11: Counter 9 increments only for a clean, non-runt frame with `rx_ok` and `rx_ready` both set. The error counters update whatever the value of `rx_ready`.
- R12: A counter at all-ones stays at all-ones under further increments. An increment that would pass all-ones lands on all-ones.
- R13: `dump_done` pulses for one cycle in the cycle after index 11. Commands that arrive while a stream is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_done | input | 1 | Transmit completion report valid |
| tx_sent | input | 1 | Frame went out on the wire |
| tx_max_coll | input | 1 | Frame dropped at the collision limit |
| tx_late_coll | input | 1 | Collision after the slot time |
| tx_underrun | input | 1 | Attempt ended by a DMA underrun |
| tx_carrier_lost | input | 1 | Carrier sense dropped during transmission |
| tx_deferred | input | 1 | Frame waited for the line to go quiet |
| tx_coll_cnt | input | COLL_W | Collisions seen in this report |
| rx_done | input | 1 | Receive completion report valid |
| rx_ok | input | 1 | Frame fully stored in memory |
| rx_crc_bad | input | 1 | CRC check failed |
| rx_misaligned | input | 1 | Frame ended off an octet boundary |
| rx_runt | input | 1 | Frame shorter than the minimum |
| rx_ready | input | 1 | Receive unit is in its ready state |
| cmd_dump | input | 1 | Dump request pulse |
| cmd_dump_clr | input | 1 | Dump-and-clear request pulse |
| dump_valid | output | 1 | Stream word valid |
| dump_idx | output | 4 | Index of the current word |
| dump_data | output | CTR_W | Counter value of the current word |
| dump_done | output | 1 | One-cycle pulse after the last word |

## Verification
On every cycle, the assertions check that the bank holds still when no report and no clear arrives. They also check that counters never fall except through a clear, and that a saturated counter stays saturated. For the stream, they check that the index advances by one from 0 to 11 even when commands arrive mid-stream, and that exactly one done pulse follows. Only the bench's scenarios can show the classification rules: which counter each flag combination reaches, collision totals for late and limit frames, per-attempt underruns, and rx_ready gating good frames but not errors. The same goes for the snapshot values seen in the stream, and for reports made during a clearing stream landing in the new bank.

// File: rtl/mac_stats_pkg.sv
// Shared constants and counter identifiers for the MAC statistics bank.
// Assumes a fixed bank of twelve counters. The identifier values are the
// stream order that software relies on.
package mac_stats_pkg;
    localparam int NUM_CTR = 12;
    localparam int IDX_W   = $clog2(NUM_CTR);

    typedef enum logic [IDX_W-1:0] {
        CI_TX_SENT     = 4'd0,
        CI_TX_MAXCOLL  = 4'd1,
        CI_TX_LATE     = 4'd2,
        CI_TX_UNDERRUN = 4'd3,
        CI_TX_CARRIER  = 4'd4,
        CI_TX_DEFER    = 4'd5,
        CI_TX_ONECOLL  = 4'd6,
        CI_TX_MANYCOLL = 4'd7,
        CI_TX_COLLSUM  = 4'd8,
        CI_RX_GOOD     = 4'd9,
        CI_RX_CRC      = 4'd10,
        CI_RX_ALIGN    = 4'd11
    } ctr_id_e;
endpackage

// File: rtl/mac_stats_classify.sv
// Turns one transmit report and one receive report per cycle into a
// per-counter increment vector. Purely combinational. Assumes a report's
// flags are only meaningful while its done strobe is high.
module mac_stats_classify
    import mac_stats_pkg::*;
#(
    parameter int COLL_W = 5
) (
    input  logic                             tx_done,
    input  logic                             tx_sent,
    input  logic                             tx_max_coll,
    input  logic                             tx_late_coll,
    input  logic                             tx_underrun,
    input  logic                             tx_carrier_lost,
    input  logic                             tx_deferred,
    input  logic [COLL_W-1:0]                tx_coll_cnt,
    input  logic                             rx_done,
    input  logic                             rx_ok,
    input  logic                             rx_crc_bad,
    input  logic                             rx_misaligned,
    input  logic                             rx_runt,
    input  logic                             rx_ready,
    output logic [NUM_CTR-1:0][COLL_W-1:0]   inc
);
    logic rx_err_counted;

    // Map report flags onto counter increments.
    always_comb begin
        inc            = '0;
        rx_err_counted = rx_crc_bad & ~rx_runt;
        if (tx_done) begin
            inc[CI_TX_SENT]     = COLL_W'(tx_sent);
            inc[CI_TX_MAXCOLL]  = COLL_W'(tx_max_coll);
            inc[CI_TX_LATE]     = COLL_W'(tx_late_coll);
            inc[CI_TX_UNDERRUN] = COLL_W'(tx_underrun);
            inc[CI_TX_CARRIER]  = COLL_W'(tx_sent & tx_carrier_lost);
            inc[CI_TX_DEFER]    = COLL_W'(tx_deferred);
            inc[CI_TX_ONECOLL]  = COLL_W'(tx_sent && (tx_coll_cnt == COLL_W'(1)));
            inc[CI_TX_MANYCOLL] = COLL_W'(tx_sent && (tx_coll_cnt > COLL_W'(1)));
            inc[CI_TX_COLLSUM]  = tx_coll_cnt;
        end
        if (rx_done) begin
            inc[CI_RX_GOOD]  = COLL_W'(rx_ok & rx_ready & ~rx_crc_bad & ~rx_runt);
            inc[CI_RX_CRC]   = COLL_W'(rx_err_counted & ~rx_misaligned);
            inc[CI_RX_ALIGN] = COLL_W'(rx_err_counted & rx_misaligned);
        end
    end
endmodule

// File: rtl/mac_stats_ctr.sv
// One saturating event counter with a synchronous clear. The clear and an
// increment in the same cycle yield the increment on a zero base.
// Assumes INC_W does not exceed CTR_W.
module mac_stats_ctr #(
    parameter int CTR_W = 32,
    parameter int INC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [INC_W-1:0] inc,
    output logic [CTR_W-1:0] count
);
    logic [CTR_W:0] sum;

    // Widened add so that an overflow shows up as a carry.
    always_comb begin
        sum = (clear ? '0 : {1'b0, count}) + (CTR_W+1)'(inc);
    end

    // Register the count, pinning it at all-ones on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (sum[CTR_W])
            count <= '1;
        else
            count <= sum[CTR_W-1:0];
    end
endmodule

// File: rtl/mac_stats_dump.sv
// Command sequencer. On an accepted command it snapshots the bank and
// streams it one word per cycle, then pulses done. Assumes the caller
// applies clear_now to the live bank on the snapshot cycle. Commands
// seen while streaming are dropped.
module mac_stats_dump
    import mac_stats_pkg::*;
#(
    parameter int CTR_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmd_dump,
    input  logic                           cmd_dump_clr,
    input  logic [NUM_CTR-1:0][CTR_W-1:0]  bank,
    output logic                           clear_now,
    output logic                           dump_valid,
    output logic [IDX_W-1:0]               dump_idx,
    output logic [CTR_W-1:0]               dump_data,
    output logic                           dump_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CTR - 1);

    logic                          busy;
    logic                          start;
    logic [NUM_CTR-1:0][CTR_W-1:0] snap;

    // Accept a command only while idle.
    always_comb begin
        start     = ~busy & (cmd_dump | cmd_dump_clr);
        clear_now = start & cmd_dump_clr;
    end

    // Stream state: busy flag, word index and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            dump_idx  <= '0;
            dump_done <= 1'b0;
        end else begin
            dump_done <= 1'b0;
            if (start) begin
                busy     <= 1'b1;
                dump_idx <= '0;
            end else if (busy) begin
                if (dump_idx == LAST_IDX) begin
                    busy      <= 1'b0;
                    dump_idx  <= '0;
                    dump_done <= 1'b1;
                end else begin
                    dump_idx <= dump_idx + 1'b1;
                end
            end
        end
    end

    // Capture the whole bank on the accepting cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap <= '0;
        else if (start)
            snap <= bank;
    end

    // Present the selected snapshot word.
    always_comb begin
        dump_valid = busy;
        dump_data  = busy ? snap[dump_idx] : '0;
    end
endmodule

// File: rtl/mac_stats_bank.sv
// Top of the MAC statistics bank: classifier, twelve saturating counters
// and the dump sequencer. Assumes at most one transmit and one receive
// report per cycle, each a single-cycle strobe.
module mac_stats_bank
    import mac_stats_pkg::*;
#(
    parameter int CTR_W  = 32,
    parameter int COLL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_done,
    input  logic              tx_sent,
    input  logic              tx_max_coll,
    input  logic              tx_late_coll,
    input  logic              tx_underrun,
    input  logic              tx_carrier_lost,
    input  logic              tx_deferred,
    input  logic [COLL_W-1:0] tx_coll_cnt,
    input  logic              rx_done,
    input  logic              rx_ok,
    input  logic              rx_crc_bad,
    input  logic              rx_misaligned,
    input  logic              rx_runt,
    input  logic              rx_ready,
    input  logic              cmd_dump,
    input  logic              cmd_dump_clr,
    output logic              dump_valid,
    output logic [3:0]        dump_idx,
    output logic [CTR_W-1:0]  dump_data,
    output logic              dump_done
);
    logic [NUM_CTR-1:0][COLL_W-1:0] inc;
    logic [NUM_CTR-1:0][CTR_W-1:0]  bank;
    logic                           clear_now;

    mac_stats_classify #(.COLL_W(COLL_W)) u_classify (
        .tx_done         (tx_done),
        .tx_sent         (tx_sent),
        .tx_max_coll     (tx_max_coll),
        .tx_late_coll    (tx_late_coll),
        .tx_underrun     (tx_underrun),
        .tx_carrier_lost (tx_carrier_lost),
        .tx_deferred     (tx_deferred),
        .tx_coll_cnt     (tx_coll_cnt),
        .rx_done         (rx_done),
        .rx_ok           (rx_ok),
        .rx_crc_bad      (rx_crc_bad),
        .rx_misaligned   (rx_misaligned),
        .rx_runt         (rx_runt),
        .rx_ready        (rx_ready),
        .inc             (inc)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        mac_stats_ctr #(.CTR_W(CTR_W), .INC_W(COLL_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clear_now),
            .inc   (inc[g]),
            .count (bank[g])
        );
    end

    mac_stats_dump #(.CTR_W(CTR_W)) u_dump (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_dump     (cmd_dump),
        .cmd_dump_clr (cmd_dump_clr),
        .bank         (bank),
        .clear_now    (clear_now),
        .dump_valid   (dump_valid),
        .dump_idx     (dump_idx),
        .dump_data    (dump_data),
        .dump_done    (dump_done)
    );
endmodule

// File: rtl/mac_stats_bank_chk.sv
// Property checker for mac_stats_bank, attached by bind. It watches the
// command ports, the stream outputs, the live bank and the clear strobe.
module mac_stats_bank_chk
    import mac_stats_pkg::*;
#(
    parameter int CTR_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tx_done,
    input logic                          rx_done,
    input logic                          cmd_dump,
    input logic                          cmd_dump_clr,
    input logic                          dump_valid,
    input logic [3:0]                    dump_idx,
    input logic                          dump_done,
    input logic                          clear_now,
    input logic [NUM_CTR-1:0][CTR_W-1:0] bank
);
    // R1
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_done && !rx_done && !clear_now) |=> $stable(bank));

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_valid && dump_idx != 4'(NUM_CTR - 1)) |=> (dump_valid && dump_idx == $past(dump_idx) + 4'd1));

    // R2
    stream_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dump_valid && (cmd_dump || cmd_dump_clr)) |=> (dump_valid && dump_idx == 4'd0));

    // R13
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_valid && dump_idx == 4'(NUM_CTR - 1)) |=> (dump_done && !dump_valid));

    // R13
    done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dump_done |-> !dump_valid);

    // R13
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dump_done |=> !dump_done);

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr_chk
        // R3
        no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clear_now |=> bank[g] >= $past(bank[g]));

        // R12
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bank[g] == '1 && !clear_now) |=> bank[g] == '1);
    end
endmodule

bind mac_stats_bank mac_stats_bank_chk #(.CTR_W(CTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_done      (tx_done),
    .rx_done      (rx_done),
    .cmd_dump     (cmd_dump),
    .cmd_dump_clr (cmd_dump_clr),
    .dump_valid   (dump_valid),
    .dump_idx     (dump_idx),
    .dump_done    (dump_done),
    .clear_now    (clear_now),
    .bank         (bank)
);

// File: tb/mac_stats_bank_tb.sv
`timescale 1ns/1ps
// Directed bench for mac_stats_bank. Narrow counters make saturation
// reachable. A reference model of the bank is kept from the requirements.
module mac_stats_bank_tb;
    localparam int W    = 8;
    localparam int CW   = 5;
    localparam int NC   = 12;
    localparam int MAXV = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tx_done, tx_sent, tx_max_coll, tx_late_coll, tx_underrun;
    logic          tx_carrier_lost, tx_deferred;
    logic [CW-1:0] tx_coll_cnt;
    logic          rx_done, rx_ok, rx_crc_bad, rx_misaligned, rx_runt, rx_ready;
    logic          cmd_dump, cmd_dump_clr;
    logic          dump_valid, dump_done;
    logic [3:0]    dump_idx;
    logic [W-1:0]  dump_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int exp_q [NC];
    int snap_q[NC];

    always #4 clk = ~clk;

    mac_stats_bank #(.CTR_W(W), .COLL_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_done(tx_done), .tx_sent(tx_sent), .tx_max_coll(tx_max_coll),
        .tx_late_coll(tx_late_coll), .tx_underrun(tx_underrun),
        .tx_carrier_lost(tx_carrier_lost), .tx_deferred(tx_deferred),
        .tx_coll_cnt(tx_coll_cnt),
        .rx_done(rx_done), .rx_ok(rx_ok), .rx_crc_bad(rx_crc_bad),
        .rx_misaligned(rx_misaligned), .rx_runt(rx_runt), .rx_ready(rx_ready),
        .cmd_dump(cmd_dump), .cmd_dump_clr(cmd_dump_clr),
        .dump_valid(dump_valid), .dump_idx(dump_idx),
        .dump_data(dump_data), .dump_done(dump_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void bump(input int i, input int by);
        exp_q[i] = (exp_q[i] + by > MAXV) ? MAXV : exp_q[i] + by;
    endfunction

    task automatic idle_inputs();
        tx_done = 0; tx_sent = 0; tx_max_coll = 0; tx_late_coll = 0;
        tx_underrun = 0; tx_carrier_lost = 0; tx_deferred = 0; tx_coll_cnt = '0;
        rx_done = 0; rx_ok = 0; rx_crc_bad = 0; rx_misaligned = 0; rx_runt = 0;
        rx_ready = 0; cmd_dump = 0; cmd_dump_clr = 0;
    endtask

    // Drive transmit report fields and update the model. Called at a negedge.
    task automatic set_tx(input bit s, input bit mx, input bit lt, input bit ur,
                          input bit cl, input bit df, input int cc);
        tx_done = 1; tx_sent = s; tx_max_coll = mx; tx_late_coll = lt;
        tx_underrun = ur; tx_carrier_lost = cl; tx_deferred = df; tx_coll_cnt = CW'(cc);
        if (s) begin
            bump(0, 1);
            if (cl) bump(4, 1);
            if (cc == 1) bump(6, 1);
            if (cc >= 2) bump(7, 1);
        end
        if (mx) bump(1, 1);
        if (lt) bump(2, 1);
        if (ur) bump(3, 1);
        if (df) bump(5, 1);
        bump(8, cc);
    endtask

    task automatic tx_frame(input bit s, input bit mx, input bit lt, input bit ur,
                            input bit cl, input bit df, input int cc);
        @(negedge clk);
        set_tx(s, mx, lt, ur, cl, df, cc);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic rx_frame(input bit ok, input bit crc, input bit mis,
                            input bit runt, input bit rdy);
        @(negedge clk);
        rx_done = 1; rx_ok = ok; rx_crc_bad = crc; rx_misaligned = mis;
        rx_runt = runt; rx_ready = rdy;
        if (ok && rdy && !crc && !runt) bump(9, 1);
        if (crc && !runt) begin
            if (mis) bump(11, 1);
            else     bump(10, 1);
        end
        @(negedge clk);
        idle_inputs();
    endtask

    // Issue a command and check the stream against the model snapshot.
    // ev_at: word index after which a transmit report is injected (-1 none).
    // cmd_at: word index after which a stray command is pulsed (-1 none).
    task automatic run_dump(input bit clr, input string req, input int ev_at, input int cmd_at);
        @(negedge clk);
        if (clr) cmd_dump_clr = 1; else cmd_dump = 1;
        foreach (exp_q[i]) snap_q[i] = exp_q[i];
        if (clr) foreach (exp_q[i]) exp_q[i] = 0;
        @(negedge clk);
        idle_inputs();
        for (int k = 0; k < NC; k++) begin
            check(dump_valid === 1'b1, {req, " valid"}, int'(dump_valid), 1);
            check(dump_idx == 4'(k), {req, " R2 index"}, int'(dump_idx), k);
            check(int'(dump_data) == snap_q[k], {req, " R2 word"}, int'(dump_data), snap_q[k]);
            check(dump_done === 1'b0, {req, " R13 early done"}, int'(dump_done), 0);
            if (k == ev_at) set_tx(1, 0, 0, 0, 0, 0, 3);
            if (k == cmd_at) cmd_dump_clr = 1;
            @(negedge clk);
            idle_inputs();
        end
        check(dump_done === 1'b1, {req, " R13 done pulse"}, int'(dump_done), 1);
        check(dump_valid === 1'b0, {req, " R13 valid after last"}, int'(dump_valid), 0);
        @(negedge clk);
        check(dump_done === 1'b0, {req, " R13 done one cycle"}, int'(dump_done), 0);
    endtask

    task automatic t_reset();
        check(dump_valid === 1'b0, "R2 reset valid low", int'(dump_valid), 0);
        check(dump_done === 1'b0, "R13 reset done low", int'(dump_done), 0);
        run_dump(0, "reset R1 zeros", -1, -1);
    endtask

    task automatic t_tx_mix();
        tx_frame(1, 0, 0, 0, 0, 0, 0);   // R5 clean send
        tx_frame(1, 0, 0, 0, 0, 1, 1);   // R5 one collision, R9 deferred
        tx_frame(1, 0, 0, 0, 1, 0, 4);   // R5 many, R9 carrier lost
        tx_frame(0, 1, 0, 0, 0, 0, 16);  // R7 limit drop, R6 collisions
        tx_frame(0, 0, 1, 0, 0, 0, 2);   // R7 late, R6 collisions
        tx_frame(0, 0, 0, 1, 1, 0, 0);   // R8 underrun, R9 lost carrier unsent
        tx_frame(0, 0, 0, 1, 0, 0, 0);   // R8 second attempt same frame
        tx_frame(1, 0, 0, 1, 0, 0, 0);   // R8 third attempt then sent
        run_dump(0, "tx mix R5 R6 R7 R8 R9", -1, -1);
    endtask

    task automatic t_rx_mix();
        rx_frame(1, 0, 0, 0, 1);  // R11 good
        rx_frame(1, 0, 0, 0, 0);  // R11 good but not ready: not counted
        rx_frame(0, 1, 0, 0, 0);  // R10 aligned CRC, R11 not ready
        rx_frame(0, 1, 1, 0, 1);  // R10 misaligned CRC
        rx_frame(0, 1, 1, 1, 1);  // R10 runt excluded
        rx_frame(0, 1, 1, 0, 0);  // R11 alignment counts when not ready
        run_dump(0, "rx mix R10 R11", -1, -1);
    endtask

    task automatic t_hold();
        repeat (20) @(negedge clk);
        run_dump(0, "idle R1 R3 unchanged", -1, -1);
    endtask

    task automatic t_clear();
        run_dump(1, "clear R4", 4, -1);
        run_dump(0, "after clear R4 event kept", -1, -1);
    endtask

    task automatic t_ignore();
        run_dump(0, "stray cmd R13", -1, 5);
        repeat (3) begin
            check(dump_valid === 1'b0, "R13 stray command ignored", int'(dump_valid), 0);
            @(negedge clk);
        end
        run_dump(0, "stray cmd R13 no clear", -1, -1);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 10; i++) tx_frame(1, 0, 0, 0, 0, 0, 31);
        run_dump(0, "R12 saturate", -1, -1);
        tx_frame(1, 0, 0, 0, 0, 0, 31);
        run_dump(1, "R12 stays saturated", -1, -1);
        run_dump(0, "R4 cleared from saturation", -1, -1);
    endtask

    initial begin
        idle_inputs();
        foreach (exp_q[i]) exp_q[i] = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_tx_mix();
        t_rx_mix();
        t_hold();
        t_clear();
        t_ignore();
        t_saturate();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule